// File: doc/BRIEF.md
# One-Shot Interval Timer

This block is a down-counter for timed events. Software writes a start value, and the counter then counts down by one on each tick of a prescaled clock. When the count passes below zero it wraps to all ones. At that point the block raises an interrupt request and stops. It does not reload by itself. Counting starts again only when software writes another start value.

A 2-bit select input chooses one of four prescaler divide ratios of the system clock. The four ratios are parameters. A prescaler tick is only counted while the timer is running, and a write restarts the prescaler phase. Because of this, the time from a write of value V to the wrap is exactly (V+1)·D system clock cycles, where D is the selected ratio. The interrupt flag stays pending until it is acknowledged or until the next write. An enable input masks the request output without discarding the pending flag.

Top module: `oneshot_interval_timer`

## Requirements
- R1: After reset the count is 0, the running output is low and the interrupt request is low.
- R2: A load strobe makes the count equal to the load data one cycle later, with the running output high.
- R3: Select codes 0, 1, 2 and 3 pick the divide ratios DIV0, DIV1, DIV2 and DIV3. While running, the count drops by exactly one every D cycles, so n cycles after a load of V it reads V − floor(n/D).
- R4: On the tick that would take the count below 0, the count becomes all ones, the running output falls and the interrupt flag becomes pending. This happens (V+1)·D cycles after the load.
- R5: While not running and with no load, the count holds its value.
- R6: A pending interrupt flag stays set until the acknowledge input is high. The acknowledge clears it on the next cycle. If an overflow and an acknowledge arrive in the same cycle, the overflow wins.
- R7: The request output is the pending flag gated by the enable input. A low enable hides the flag but does not clear it.
- R8: A load in the same cycle as a tick takes the load value, and the decrement is dropped.
- R9: A load clears a pending interrupt flag.
- R10: A load of 0 runs for one full tick period and then wraps to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Start strobe: capture load_val_i and start counting |
| load_val_i | input | CNT_W | Start value |
| tick_sel_i | input | 2 | Prescaler ratio select |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_ack_i | input | 1 | Clears the pending interrupt flag |
| count_o | output | CNT_W | Current count |
| running_o | output | 1 | High from load until overflow |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with an 8-bit count and the divide ratios 1, 2, 3 and 5. With these settings a complete countdown takes at most a few thousand cycles. Under ratio 1 the bench sweeps every one of the 256 start values and checks the count on every cycle against V − floor(n/D), up to and including the wrap. Under the other three ratios it runs the start values at the edges of the range. The short ratios also make it easy to place a reload exactly on a tick edge and to line up an acknowledge or a mask change with the overflow.

// File: rtl/oneshot_interval_timer.sv
module oneshot_interval_timer #(
  parameter int CNT_W = 8,
  parameter int DIV0  = 4,
  parameter int DIV1  = 64,
  parameter int DIV2  = 1024,
  parameter int DIV3  = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [1:0]       tick_sel_i,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             irq_o
);
  localparam int MAX01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAX23 = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int DMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int PRE_W = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic [PRE_W-1:0] pre_q, lim;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, pend_q, tick, wrap;

  always_comb begin
    case (tick_sel_i)
      2'd0:    lim = PRE_W'(DIV0 - 1);
      2'd1:    lim = PRE_W'(DIV1 - 1);
      2'd2:    lim = PRE_W'(DIV2 - 1);
      default: lim = PRE_W'(DIV3 - 1);
    endcase
  end

  assign tick = run_q && (pre_q >= lim);
  assign wrap = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      pre_q  <= '0;
      cnt_q  <= load_val_i;
      run_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else if (run_q) begin
        pre_q <= pre_q + 1'b1;
      end
      if (wrap) begin
        run_q  <= 1'b0;
        pend_q <= 1'b1;
      end else if (irq_ack_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign count_o   = cnt_q;
  assign running_o = run_q;
  assign irq_o     = pend_q & irq_en_i;
endmodule

// File: rtl/oneshot_interval_timer_chk.sv
module oneshot_interval_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             irq_en_i,
  input logic             irq_ack_i,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_val_i)) && running_o && !irq_o);

  assert_stop_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> (count_o == ONES));

  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !load_i) |=> $stable(count_o) && !running_o);

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !load_i) |=> (count_o == $past(count_o)) ||
                               (count_o == $past(count_o) - 1'b1));

  assert_pending_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i && !load_i && irq_en_i) |=> irq_o || !irq_en_i);

  assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !irq_o);
endmodule

bind oneshot_interval_timer oneshot_interval_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
  .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i), .count_o(count_o),
  .running_o(running_o), .irq_o(irq_o)
);

// File: tb/oneshot_interval_timer_test.sv
`timescale 1ns/100ps
module oneshot_interval_timer_test;
  localparam int W = 8;
  localparam int D0 = 1, D1 = 2, D2 = 3, D3 = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_i = 1'b0, irq_en_i = 1'b0, irq_ack_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic [1:0] tick_sel_i = 2'd0;
  logic [W-1:0] count_o;
  logic running_o, irq_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  oneshot_interval_timer #(.CNT_W(W), .DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .tick_sel_i(tick_sel_i), .irq_en_i(irq_en_i), .irq_ack_i(irq_ack_i),
    .count_o(count_o), .running_o(running_o), .irq_o(irq_o));

  always #2.5 clk = ~clk;

  function automatic int ratio(input int s);
    case (s)
      0: return D0;
      1: return D1;
      2: return D2;
      default: return D3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_state(input string req, input int c, input bit r, input bit q);
    chk(count_o == W'(c), req, count_o, c);
    chk(running_o == r, req, running_o, r);
    chk(irq_o == q, req, irq_o, q);
  endtask

  task automatic load(input int v, input int s);
    load_i = 1'b1; load_val_i = W'(v); tick_sel_i = 2'(s);
    step();
    load_i = 1'b0;
  endtask

  task automatic run(input int v, input int s, input bit en);
    int d = ratio(s);
    irq_en_i = en;
    load(v, s);
    expect_state("R2", v, 1'b1, 1'b0);
    for (int n = 1; n <= (v + 1) * d; n++) begin
      step();
      if (n < (v + 1) * d) expect_state("R3", v - n / d, 1'b1, 1'b0);
      else expect_state(v == 0 ? "R10" : "R4", 255, 1'b0, en);
    end
  endtask

  initial begin
    #12; step();
    expect_state("R1", 0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step();
    expect_state("R1", 0, 1'b0, 1'b0);

    for (int v = 0; v < 256; v++) run(v, 0, 1'b1);
    for (int s = 1; s < 4; s++) begin
      run(0, s, 1'b1); run(1, s, 1'b1); run(2, s, 1'b1);
      run(127, s, 1'b1); run(255, s, 1'b1);
    end

    run(3, 2, 1'b1);
    for (int i = 0; i < 12; i++) begin
      step();
      expect_state("R5", 255, 1'b0, 1'b1);
    end
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
    expect_state("R6", 255, 1'b0, 1'b0);
    step();
    expect_state("R6", 255, 1'b0, 1'b0);

    run(2, 1, 1'b0);
    step();
    expect_state("R7", 255, 1'b0, 1'b0);
    irq_en_i = 1'b1; #1;
    chk(irq_o == 1'b1, "R7", irq_o, 1);

    load(9, 3);
    expect_state("R9", 9, 1'b1, 1'b0);

    load(10, 0);
    load(20, 0);
    expect_state("R8", 20, 1'b1, 1'b0);
    load(30, 1);
    step();
    load(40, 1);
    expect_state("R8", 40, 1'b1, 1'b0);
    step();
    expect_state("R3", 40, 1'b1, 1'b0);
    step();
    expect_state("R3", 39, 1'b1, 1'b0);

    load(0, 3);
    for (int i = 0; i < 4; i++) begin
      step();
      expect_state("R10", 0, 1'b1, 1'b0);
    end
    irq_ack_i = 1'b1;
    step();
    irq_ack_i = 1'b0;
    expect_state("R6", 255, 1'b0, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule